// File: doc/BRIEF.md
# Dwell Pointer Scheduler with Congestion Guard

This block performs the time-domain half of a beam's switching. Every arriving packet has already been stored in a shared buffer, and a pointer to it arrives here together with a dwell number, a multicast flag and a priority. The block files each pointer into a queue for its destination dwell. A multicast pointer is copied into every dwell's queue, so the packet body is never duplicated. Later the block hands the pointers out in dwell order, and this order is the order in which the shared buffer is read for the downlink.

Each dwell queue has two banks. During a frame, one bank collects new pointers while the other bank, filled during the previous frame, is drained. A one-cycle frame boundary pulse swaps the roles of the banks for all dwells at once. Each dwell's occupancy is compared with a programmable threshold set below full. When a dwell is congested, low-priority arrivals for that dwell are refused, so the space left is kept for higher-priority traffic.

Top module: `dwell_ptr_sched`

## Requirements
- R1: During and after reset, and until the first frame boundary, `out_valid`, `out_eof`, `in_drop` and every bit of `cong` are 0.
- R2: A unicast arrival (`in_mcast`=0) is filed only in the queue of the dwell named by the 3-bit `in_dwell` field. Within one dwell, pointers are delivered in arrival order.
- R3: A multicast arrival (`in_mcast`=1) ignores `in_dwell`. Each of the eight dwell queues decides on its own whether to accept a copy of the pointer.
- R4: Pointers filed during a frame appear on the output only after the next `frame_swap` pulse. At that pulse the drained bank is emptied and becomes the collecting bank. `in_valid` must be low in a `frame_swap` cycle.
- R5: After a swap, output begins at dwell 0. Output moves to the next higher dwell only when the current dwell's draining bank is empty. `out_dwell` carries the dwell number of each pointer.
- R6: When dwell 7's draining bank is empty, `out_eof` is high for exactly one cycle with `out_valid` low. Both then stay low until the next swap.
- R7: `cong[d]` is high exactly while dwell d's occupancy is at or above `cfg_thresh`. Occupancy is the unread entries of the draining bank plus the entries of the collecting bank. The flag falls as soon as occupancy drops below the threshold.
- R8: An arrival at a congested dwell whose 2-bit `in_prio` is numerically below `cfg_min_prio` is refused by that dwell. An arrival at or above the minimum is still accepted.
- R9: A dwell whose collecting bank holds DEPTH entries refuses arrivals of any priority.
- R10: `in_drop` is high in the cycle after an arrival that at least one targeted dwell refused, and low otherwise.
- R11: While `out_valid` is high and `out_ready` is low, `out_ptr` and `out_dwell` hold their values. A pointer is consumed only on a cycle where `out_valid` and `out_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_swap | input | 1 | Frame boundary pulse; swaps the banks |
| in_valid | input | 1 | Arrival strobe |
| in_ptr | input | PTR_W | Pointer-table index of the packet |
| in_dwell | input | DSEL_W | Destination dwell for unicast |
| in_mcast | input | 1 | Copy to all dwells |
| in_prio | input | 2 | Arrival priority, 3 highest |
| cfg_thresh | input | OCC_W | Congestion occupancy threshold |
| cfg_min_prio | input | 2 | Lowest priority admitted while congested |
| in_drop | output | 1 | Arrival refused by at least one dwell |
| cong | output | NUM_DWELL | Per-dwell congestion flags |
| out_valid | output | 1 | Pointer available |
| out_ready | input | 1 | Consumer takes pointer |
| out_ptr | output | PTR_W | Pointer to read from the shared buffer |
| out_dwell | output | DSEL_W | Dwell tag of out_ptr |
| out_eof | output | 1 | All dwells drained this frame |

## Verification
The bench builds the block with DEPTH=4 and 8-bit pointers, keeping eight dwells so that the 3-bit field is decoded over its full range. With the threshold at 3 and the minimum priority at 2, a handful of arrivals is enough to make a queue congested, refuse a low-priority packet, accept a high-priority one, and then fill the queue completely. A multicast that one full dwell partly refuses is also within reach. Right after a swap, the unread draining bank alone makes a dwell congested, and the bench watches that flag fall while the dwell drains under intermittent `out_ready`.

// File: rtl/dps_pkg.sv
// Shared definitions for the dwell pointer scheduler.
// Assumes priorities are 2-bit values where a larger value is more important.
package dps_pkg;
    localparam int PRIO_W = 2;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/dps_fanout.sv
// Dwell write decoder: converts a dwell number plus multicast flag into
// a per-dwell write request vector. Assumes in_dwell < NUM_DWELL for unicast.
module dps_fanout #(
    parameter int NUM_DWELL = 8,
    parameter int DSEL_W    = 3
) (
    input  logic                 in_valid,
    input  logic [DSEL_W-1:0]    in_dwell,
    input  logic                 in_mcast,
    output logic [NUM_DWELL-1:0] wr_req
);
    for (genvar d = 0; d < NUM_DWELL; d++) begin : g_req
        // One request line per dwell: a multicast arrival targets every dwell.
        assign wr_req[d] = in_valid && (in_mcast || (in_dwell == DSEL_W'(d)));
    end
endmodule

// File: rtl/dps_dwell_queue.sv
// One dwell's double-banked pointer queue with occupancy-based admission.
// The bank selection (wr_bank) is shared by all dwells and driven by the top.
// Assumes DEPTH >= 2 and that wr_req is never raised in a swap cycle.
module dps_dwell_queue
    import dps_pkg::*;
#(
    parameter int PTR_W = 12,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int OCC_W = $clog2(2 * DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swap,
    input  logic             wr_bank,
    input  logic             wr_req,
    input  logic [PTR_W-1:0] wr_ptr,
    input  prio_t            wr_prio,
    input  logic [OCC_W-1:0] cfg_thresh,
    input  prio_t            cfg_min_prio,
    input  logic             rd_pop,
    output logic             wr_rej,
    output logic             rd_empty,
    output logic [PTR_W-1:0] rd_data,
    output logic             cong
);
    localparam int AW = $clog2(DEPTH);

    logic [PTR_W-1:0] mem [2][DEPTH];
    logic [CNT_W-1:0] wcnt;
    logic [CNT_W-1:0] rcnt;
    logic [CNT_W-1:0] rptr;
    logic [OCC_W-1:0] occ;
    logic             wfull;
    logic             wr_acc;

    // Occupancy spans both banks: unread draining entries plus collected ones.
    always_comb begin
        occ      = OCC_W'(wcnt) + OCC_W'(rcnt - rptr);
        wfull    = (wcnt == CNT_W'(DEPTH));
        cong     = (occ >= cfg_thresh);
        wr_rej   = wr_req && (wfull || (cong && (wr_prio < cfg_min_prio)));
        wr_acc   = wr_req && !wr_rej && !swap;
        rd_empty = (rptr == rcnt);
        rd_data  = mem[~wr_bank][rptr[AW-1:0]];
    end

    // Counter upkeep: swap hands the collected count to the drain side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            rcnt <= '0;
            rptr <= '0;
        end else if (swap) begin
            rcnt <= wcnt;
            rptr <= '0;
            wcnt <= '0;
        end else begin
            if (wr_acc) begin
                wcnt <= wcnt + CNT_W'(1);
            end
            if (rd_pop && !rd_empty) begin
                rptr <= rptr + CNT_W'(1);
            end
        end
    end

    // Pointer storage write into the collecting bank.
    always_ff @(posedge clk) begin
        if (wr_acc) begin
            mem[wr_bank][wcnt[AW-1:0]] <= wr_ptr;
        end
    end
endmodule

// File: rtl/dps_drain_seq.sv
// Drain sequencer: walks dwells in ascending order after each swap,
// stepping past a dwell once its draining bank is empty, then flags end of frame.
// Assumes NUM_DWELL >= 2.
module dps_drain_seq #(
    parameter int NUM_DWELL = 8,
    parameter int DSEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap,
    input  logic              cur_empty,
    output logic              active,
    output logic [DSEL_W-1:0] dsel,
    output logic              eof
);
    localparam logic [DSEL_W-1:0] LAST = DSEL_W'(NUM_DWELL - 1);

    // End of frame: last dwell empty while draining and no swap pending.
    assign eof = active && cur_empty && (dsel == LAST) && !swap;

    // Dwell pointer advance and drain activity tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            dsel   <= '0;
        end else if (swap) begin
            active <= 1'b1;
            dsel   <= '0;
        end else if (active && cur_empty) begin
            if (dsel == LAST) begin
                active <= 1'b0;
            end else begin
                dsel <= dsel + DSEL_W'(1);
            end
        end
    end
endmodule

// File: rtl/dwell_ptr_sched.sv
// Top: per-dwell double-banked pointer queues feeding a sequential drain.
// Arrivals are decoded to dwell queues, admitted against congestion and
// fullness rules, and read back dwell by dwell after each frame swap.
// Assumes in_valid is low whenever frame_swap is high.
module dwell_ptr_sched
    import dps_pkg::*;
#(
    parameter int PTR_W       = 12,
    parameter int DEPTH       = 16,
    parameter int NUM_DWELL   = 8,
    localparam int DSEL_W     = $clog2(NUM_DWELL),
    localparam int CNT_W      = $clog2(DEPTH + 1),
    localparam int OCC_W      = $clog2(2 * DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_swap,
    input  logic                 in_valid,
    input  logic [PTR_W-1:0]     in_ptr,
    input  logic [DSEL_W-1:0]    in_dwell,
    input  logic                 in_mcast,
    input  logic [1:0]           in_prio,
    input  logic [OCC_W-1:0]     cfg_thresh,
    input  logic [1:0]           cfg_min_prio,
    output logic                 in_drop,
    output logic [NUM_DWELL-1:0] cong,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [PTR_W-1:0]     out_ptr,
    output logic [DSEL_W-1:0]    out_dwell,
    output logic                 out_eof
);
    logic [NUM_DWELL-1:0] wr_req;
    logic [NUM_DWELL-1:0] rej_v;
    logic [NUM_DWELL-1:0] empty_v;
    logic [NUM_DWELL-1:0] pop_v;
    logic [PTR_W-1:0]     rd_data_a [NUM_DWELL];
    logic                 wr_bank;
    logic                 active;
    logic [DSEL_W-1:0]    dsel;
    logic                 cur_empty;

    dps_fanout #(
        .NUM_DWELL (NUM_DWELL),
        .DSEL_W    (DSEL_W)
    ) u_fanout (
        .in_valid (in_valid),
        .in_dwell (in_dwell),
        .in_mcast (in_mcast),
        .wr_req   (wr_req)
    );

    for (genvar d = 0; d < NUM_DWELL; d++) begin : g_dwell
        // Pop only the dwell currently selected by the sequencer.
        assign pop_v[d] = out_valid && out_ready && (dsel == DSEL_W'(d));

        dps_dwell_queue #(
            .PTR_W (PTR_W),
            .DEPTH (DEPTH),
            .CNT_W (CNT_W),
            .OCC_W (OCC_W)
        ) u_q (
            .clk          (clk),
            .rst_n        (rst_n),
            .swap         (frame_swap),
            .wr_bank      (wr_bank),
            .wr_req       (wr_req[d]),
            .wr_ptr       (in_ptr),
            .wr_prio      (prio_t'(in_prio)),
            .cfg_thresh   (cfg_thresh),
            .cfg_min_prio (prio_t'(cfg_min_prio)),
            .rd_pop       (pop_v[d]),
            .wr_rej       (rej_v[d]),
            .rd_empty     (empty_v[d]),
            .rd_data      (rd_data_a[d]),
            .cong         (cong[d])
        );
    end

    dps_drain_seq #(
        .NUM_DWELL (NUM_DWELL),
        .DSEL_W    (DSEL_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap      (frame_swap),
        .cur_empty (cur_empty),
        .active    (active),
        .dsel      (dsel),
        .eof       (out_eof)
    );

    // Output selection from the dwell being drained.
    always_comb begin
        cur_empty = empty_v[dsel];
        out_valid = active && !cur_empty && !frame_swap;
        out_ptr   = rd_data_a[dsel];
        out_dwell = dsel;
    end

    // Global bank toggle at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank <= 1'b0;
        end else if (frame_swap) begin
            wr_bank <= ~wr_bank;
        end
    end

    // Registered refusal pulse for the previous cycle's arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_drop <= 1'b0;
        end else begin
            in_drop <= |rej_v;
        end
    end
endmodule

// File: rtl/dwell_ptr_sched_chk.sv
// Property checker for dwell_ptr_sched, attached by bind below.
// Observes top-level ports only.
module dwell_ptr_sched_chk #(
    parameter int PTR_W  = 12,
    parameter int DSEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_swap,
    input logic              in_valid,
    input logic              in_drop,
    input logic              out_valid,
    input logic              out_ready,
    input logic [PTR_W-1:0]  out_ptr,
    input logic [DSEL_W-1:0] out_dwell,
    input logic              out_eof
);
    // R4
    swap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_swap |-> !in_valid);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !frame_swap) |=>
        (frame_swap || (out_valid && $stable(out_ptr) && $stable(out_dwell))));

    // R6
    eof_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> !out_valid);

    // R6
    eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |=> !out_eof);

    // R10
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_drop |-> $past(in_valid));

    // R5
    dwell_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !$past(frame_swap)) |->
        (out_dwell >= $past(out_dwell)));
endmodule

bind dwell_ptr_sched dwell_ptr_sched_chk #(
    .PTR_W  (PTR_W),
    .DSEL_W (DSEL_W)
) u_chk (.*);

// File: tb/tb_dwell_ptr_sched.sv
module tb_dwell_ptr_sched;
    localparam int PTR_W = 8;
    localparam int DEPTH = 4;
    localparam int ND    = 8;
    localparam int THR   = 3;
    localparam int MINP  = 2;
    localparam int NVEC  = 10;

    // Vector: ptr[14:7] dwell[6:4] mcast[3] prio[2:1] expected drop[0]
    localparam logic [14:0] VEC [NVEC] = '{
        {8'h10, 3'd2, 1'b0, 2'd0, 1'b0},   // R2 first entry
        {8'h11, 3'd2, 1'b0, 2'd1, 1'b0},
        {8'h12, 3'd2, 1'b0, 2'd0, 1'b0},   // reaches threshold
        {8'h13, 3'd2, 1'b0, 2'd1, 1'b1},   // R8 low prio refused
        {8'h14, 3'd2, 1'b0, 2'd3, 1'b0},   // R8 high prio admitted, now full
        {8'h15, 3'd2, 1'b0, 2'd3, 1'b1},   // R9 full refuses any prio
        {8'h20, 3'd5, 1'b0, 2'd2, 1'b0},
        {8'h30, 3'd2, 1'b1, 2'd0, 1'b1},   // R3 multicast, dwell 2 refuses
        {8'h21, 3'd0, 1'b0, 2'd1, 1'b0},
        {8'h40, 3'd7, 1'b0, 2'd0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_swap = 1'b0;
    logic             in_valid = 1'b0;
    logic [PTR_W-1:0] in_ptr = '0;
    logic [2:0]       in_dwell = '0;
    logic             in_mcast = 1'b0;
    logic [1:0]       in_prio = '0;
    logic [3:0]       cfg_thresh = 4'(THR);
    logic [1:0]       cfg_min_prio = 2'(MINP);
    logic             in_drop;
    logic [ND-1:0]    cong;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [PTR_W-1:0] out_ptr;
    logic [2:0]       out_dwell;
    logic             out_eof;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of queue contents: collecting and draining banks.
    int mq [ND][DEPTH];
    int mw [ND];
    int rq [ND][DEPTH];
    int rc [ND];
    int rh [ND];

    always #5 clk = ~clk;

    dwell_ptr_sched #(.PTR_W(PTR_W), .DEPTH(DEPTH), .NUM_DWELL(ND)) dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ND-1:0] exp_cong();
        logic [ND-1:0] v;
        for (int d = 0; d < ND; d++) v[d] = (mw[d] + rc[d] - rh[d]) >= THR;
        return v;
    endfunction

    task automatic send(input logic [7:0] p, input int dw, input bit mc,
                        input int pr, input bit exp_drop, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_ptr = p; in_dwell = 3'(dw); in_mcast = mc; in_prio = 2'(pr);
        for (int d = 0; d < ND; d++) begin
            if (mc || d == dw) begin
                int occ;
                bit rej;
                occ = mw[d] + rc[d] - rh[d];
                rej = (mw[d] == DEPTH) || (occ >= THR && pr < MINP);
                if (!rej) begin
                    mq[d][mw[d]] = p;
                    mw[d]++;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_drop == exp_drop, tag, in_drop, exp_drop);
    endtask

    task automatic swap();
        @(negedge clk);
        frame_swap = 1'b1;
        for (int d = 0; d < ND; d++) begin
            for (int k = 0; k < DEPTH; k++) rq[d][k] = mq[d][k];
            rc[d] = mw[d]; rh[d] = 0; mw[d] = 0;
        end
        @(negedge clk);
        frame_swap = 1'b0;
    endtask

    task automatic drain(input bit toggle);
        bit fin = 1'b0;
        for (int i = 0; i < 400 && !fin; i++) begin
            @(negedge clk);
            out_ready = toggle ? i[0] : 1'b1;
            #1;
            chk(cong == exp_cong(), "R7 congestion level during drain", cong, exp_cong());
            if (out_eof) begin
                int left = 0;
                for (int d = 0; d < ND; d++) left += rc[d] - rh[d];
                chk(left == 0 && !out_valid, "R6 end of frame after all dwells", left, 0);
                fin = 1'b1;
            end else if (out_valid && out_ready) begin
                int ed = -1;
                for (int d = ND - 1; d >= 0; d--) if (rh[d] < rc[d]) ed = d;
                if (ed < 0) begin
                    chk(1'b0, "R4 unexpected pointer", out_ptr, 0);
                end else begin
                    chk(out_ptr == 8'(rq[ed][rh[ed]]), "R2 pointer order", out_ptr, rq[ed][rh[ed]]);
                    chk(out_dwell == 3'(ed), "R5 dwell tag and order", out_dwell, ed);
                    rh[ed]++;
                end
            end
        end
        chk(fin, "R6 end of frame seen", fin, 1);
        @(negedge clk);
        out_ready = 1'b0;
        chk(!out_valid && !out_eof, "R6 quiet after end of frame", {out_valid, out_eof}, 0);
    endtask

    initial begin
        for (int d = 0; d < ND; d++) begin mw[d] = 0; rc[d] = 0; rh[d] = 0; end
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_eof && !in_drop && cong == '0, "R1 state in reset",
            {out_valid, out_eof, in_drop, cong}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_eof && !in_drop && cong == '0, "R1 state after reset",
            {out_valid, out_eof, in_drop, cong}, 0);

        // Table walk: R2, R3, R8, R9, R10
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v][14:7], int'(VEC[v][6:4]), VEC[v][3], int'(VEC[v][2:1]), VEC[v][0],
                 $sformatf("R10 drop on vector %0d", v));
        end
        chk(cong == 8'h04, "R7 only dwell 2 congested", cong, 8'h04);
        chk(!out_valid, "R4 nothing before first swap", out_valid, 0);

        swap();
        #1;
        chk(out_valid && out_ptr == 8'h30 && out_dwell == 3'd0, "R5 drain starts at dwell 0",
            {out_dwell, out_ptr}, {3'd0, 8'h30});
        @(negedge clk);
        chk(out_valid && out_ptr == 8'h30, "R11 hold while stalled", out_ptr, 8'h30);

        // Draining bank alone keeps dwell 2 congested: R7, R8
        send(8'h50, 2, 1'b0, 0, 1'b1, "R8 refused on draining occupancy");
        send(8'h51, 2, 1'b0, 3, 1'b0, "R8 high priority admitted");
        chk(out_ptr == 8'h30 && out_dwell == 3'd0, "R4 new arrival not in current drain",
            out_ptr, 8'h30);

        drain(1'b1);
        swap();
        drain(1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule